// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block drives the parallel control-register port of a serial-link PHY. On its request side it takes one command at a time over a valid/ready pair: load an address, write a data word, or read a data word. On its PHY side it owns a control word, which carries a 16-bit operand field and four strobe bits. It watches a single acknowledge line and a 16-bit read-data field that come back from the PHY.

Each command becomes a chain of four-phase exchanges. The block raises one strobe and polls until acknowledge goes high. It then drops the strobe and polls until acknowledge goes low. Every poll is bounded to a fixed number of samples spaced by a parameterised gap, so a dead PHY ends the command with an error instead of hanging. A write whose data has bit 0 set puts the PHY into reset, and a PHY in reset cannot answer. In that case the block raises the write strobe and finishes without waiting.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` and `err` are 0, and every bit of `phy_ctrl` is 0.
- R2: Op code 0 (address) drives the operand onto `phy_ctrl[15:0]` and raises bit 16. It waits for acknowledge high, lowers bit 16, waits for acknowledge low, then pulses `done` with `err` low.
- R3: Op code 1 (write) first runs a full raise/ack-high/lower/ack-low exchange on bit 17 with the data on `phy_ctrl[15:0]`. It then runs the same exchange on bit 18.
- R4: When a write's data has bit 0 set, the block finishes the bit-17 exchange, then raises bit 18 and pulses `done` (err low) in the same step, with no acknowledge wait. Bit 18 stays high until the next command is accepted, and that acceptance clears it.
- R5: Op code 2 (read) raises bit 19 and waits for acknowledge high. In the cycle where the high level is seen, it captures `phy_rdata` into `rd_data`. It then lowers bit 19 and waits for acknowledge low.
- R6: The first acknowledge sample is taken in the first cycle the new strobe level is on `phy_ctrl`. Later samples follow every POLL_GAP+1 cycles. An acknowledge that arrives within the sample budget lets the command go on.
- R7: If acknowledge has not reached the wanted level by the MAX_POLLS-th sample, `done` and `err` pulse in the next cycle, all strobes go low, and the rest of the command is dropped.
- R8: The bound of R7 applies to the acknowledge-low wait as well as the acknowledge-high wait.
- R9: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while idle. `done` lasts one cycle, and `err` is never high without `done`.
- R10: Op code 3 is not a command. It is taken, raises no strobe, and gives `done` with `err` in the cycle after acceptance.
- R11: At most one strobe bit of `phy_ctrl[19:16]` is high at any time.
- R12: The operand field `phy_ctrl[15:0]` holds the accepted operand unchanged for as long as the command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, able to take a command |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 invalid |
| cmd_data | input | 16 | Address or write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout or invalid op, valid with done |
| rd_data | output | 16 | Last captured read word |
| phy_ctrl | output | 20 | Operand field [15:0], strobes [19:16] |
| phy_ack | input | 1 | PHY acknowledge (status bit 18) |
| phy_rdata | input | 16 | PHY read-data field (status bits 15:0) |

## Verification
The hardest case to reach is a timeout on the acknowledge-low leg. It needs a PHY that answers the raise correctly and then never releases. The bench PHY model has a stuck-high mode for this, and its response latency and mute switch let the bench place acknowledge just inside or just outside the sample budget. The reset-write path is reached through the model itself: when it captures data with bit 0 set, it stops acknowledging. The bench then checks that no data was stored and that the write strobe lingers until the next command.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } cr_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_UP,
        ST_ADDR_DN,
        ST_CAPD_UP,
        ST_CAPD_DN,
        ST_WR_UP,
        ST_WR_DN,
        ST_RD_UP,
        ST_RD_DN
    } cr_state_e;

    localparam int NUM_STROBES = 4;
    localparam int SB_CAPA = 0;
    localparam int SB_CAPD = 1;
    localparam int SB_WR   = 2;
    localparam int SB_RD   = 3;

endpackage

// File: rtl/phy_cr_poll.sv
module phy_cr_poll #(
    parameter int MAX_POLLS = 10,
    parameter int POLL_GAP  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic hit,
    output logic sample,
    output logic expire
);
    localparam int GAP_W = (POLL_GAP > 0) ? $clog2(POLL_GAP + 1) : 1;
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] cnt;
    } poll_t;

    poll_t d, q;

    always_comb begin
        d      = q;
        sample = run && (q.gap == '0);
        expire = sample && !hit && (q.cnt == CNT_LAST);
        if (clr) begin
            d.gap = '0;
            d.cnt = '0;
        end else if (run) begin
            if (q.gap != '0) begin
                d.gap = q.gap - 1'b1;
            end else if (!hit && !expire) begin
                d.gap = GAP_LOAD;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7
    poll_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_LAST);

    // R6
    poll_gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.gap <= GAP_LOAD);

endmodule

// File: rtl/phy_cr_pack.sv
module phy_cr_pack #(
    parameter int DATA_W      = 16,
    parameter int NUM_STROBES = 4,
    parameter int STROBE_LSB  = 16
) (
    input  logic [DATA_W-1:0]                 data,
    input  logic [NUM_STROBES-1:0]            strobes,
    output logic [STROBE_LSB+NUM_STROBES-1:0] ctrl
);
    localparam int CTRL_W = STROBE_LSB + NUM_STROBES;

    for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
        if (i < DATA_W) begin : g_data
            assign ctrl[i] = data[i];
        end else if (i >= STROBE_LSB) begin : g_stb
            assign ctrl[i] = strobes[i - STROBE_LSB];
        end else begin : g_pad
            assign ctrl[i] = 1'b0;
        end
    end

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [DATA_W-1:0]      cmd_data,
    output logic                   cmd_ready,
    output logic                   done,
    output logic                   err,
    output logic [DATA_W-1:0]      rd_data,
    output logic [DATA_W-1:0]      opnd,
    output logic [NUM_STROBES-1:0] strobes,
    input  logic                   ack,
    input  logic [DATA_W-1:0]      rdata_in,
    output logic                   poll_clr,
    output logic                   poll_run,
    output logic                   poll_hit,
    input  logic                   poll_sample,
    input  logic                   poll_expire
);
    typedef struct packed {
        cr_state_e                st;
        logic [DATA_W-1:0]        data;
        logic [NUM_STROBES-1:0]   stb;
        logic [DATA_W-1:0]        rdata;
        logic                     done;
        logic                     err;
    } seq_t;

    seq_t d, q;
    logic want_high;
    logic advance;

    always_comb begin
        unique case (q.st)
            ST_ADDR_UP, ST_CAPD_UP, ST_WR_UP, ST_RD_UP: want_high = 1'b1;
            default:                                    want_high = 1'b0;
        endcase
    end

    assign poll_run = (q.st != ST_IDLE);
    assign poll_hit = (ack == want_high);
    assign advance  = poll_sample && poll_hit;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        poll_clr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.data   = cmd_data;
                    d.stb    = '0;
                    poll_clr = 1'b1;
                    unique case (cr_op_e'(cmd_op))
                        OP_ADDR: begin
                            d.st           = ST_ADDR_UP;
                            d.stb[SB_CAPA] = 1'b1;
                        end
                        OP_WRITE: begin
                            d.st           = ST_CAPD_UP;
                            d.stb[SB_CAPD] = 1'b1;
                        end
                        OP_READ: begin
                            d.st         = ST_RD_UP;
                            d.stb[SB_RD] = 1'b1;
                        end
                        default: begin
                            d.done = 1'b1;
                            d.err  = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                if (advance) begin
                    poll_clr = 1'b1;
                    unique case (q.st)
                        ST_ADDR_UP: begin
                            d.stb[SB_CAPA] = 1'b0;
                            d.st           = ST_ADDR_DN;
                        end
                        ST_CAPD_UP: begin
                            d.stb[SB_CAPD] = 1'b0;
                            d.st           = ST_CAPD_DN;
                        end
                        ST_CAPD_DN: begin
                            d.stb[SB_WR] = 1'b1;
                            if (q.data[0]) begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                            end else begin
                                d.st = ST_WR_UP;
                            end
                        end
                        ST_WR_UP: begin
                            d.stb[SB_WR] = 1'b0;
                            d.st         = ST_WR_DN;
                        end
                        ST_RD_UP: begin
                            d.rdata      = rdata_in;
                            d.stb[SB_RD] = 1'b0;
                            d.st         = ST_RD_DN;
                        end
                        default: begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    endcase
                end else if (poll_expire) begin
                    d.st   = ST_IDLE;
                    d.stb  = '0;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign rd_data   = q.rdata;
    assign opnd      = q.data;
    assign strobes   = q.stb;

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.stb));

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> q.done);

    // R7
    err_drops_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (q.stb == '0));

    // R12
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.data));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op != 2'd3)) |=> !cmd_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done || $past(cmd_valid && cmd_ready));

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int STROBE_LSB = 16,
    parameter int MAX_POLLS  = 10,
    parameter int POLL_GAP   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cmd_valid,
    output logic                                  cmd_ready,
    input  logic [1:0]                            cmd_op,
    input  logic [DATA_W-1:0]                     cmd_data,
    output logic                                  done,
    output logic                                  err,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [STROBE_LSB+NUM_STROBES-1:0]     phy_ctrl,
    input  logic                                  phy_ack,
    input  logic [DATA_W-1:0]                     phy_rdata
);
    logic [DATA_W-1:0]      opnd;
    logic [NUM_STROBES-1:0] strobes;
    logic poll_clr, poll_run, poll_hit, poll_sample, poll_expire;

    phy_cr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .cmd_ready   (cmd_ready),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data),
        .opnd        (opnd),
        .strobes     (strobes),
        .ack         (phy_ack),
        .rdata_in    (phy_rdata),
        .poll_clr    (poll_clr),
        .poll_run    (poll_run),
        .poll_hit    (poll_hit),
        .poll_sample (poll_sample),
        .poll_expire (poll_expire)
    );

    phy_cr_poll #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (poll_clr),
        .run    (poll_run),
        .hit    (poll_hit),
        .sample (poll_sample),
        .expire (poll_expire)
    );

    phy_cr_pack #(
        .DATA_W      (DATA_W),
        .NUM_STROBES (NUM_STROBES),
        .STROBE_LSB  (STROBE_LSB)
    ) u_pack (
        .data    (opnd),
        .strobes (strobes),
        .ctrl    (phy_ctrl)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cmd_ready);

endmodule

// File: tb/phy_cr_master_tb.sv
module phy_cr_master_tb;
    localparam int G = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready, done, err;
    logic [15:0] rd_data;
    logic [19:0] phy_ctrl;
    logic        phy_ack;
    logic [15:0] phy_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phy_cr_master #(.POLL_GAP(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .err(err),
        .rd_data(rd_data), .phy_ctrl(phy_ctrl), .phy_ack(phy_ack),
        .phy_rdata(phy_rdata)
    );

    // PHY port model
    logic [15:0] m_mem [16];
    logic [15:0] m_addr, m_dat;
    logic [3:0]  m_prev;
    logic [7:0]  m_dl;
    logic        m_rst;
    int          lat = 0;
    logic        mute = 1'b0;
    logic        stuck = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] <= 16'hA000 + 16'(i);
            m_addr <= '0; m_dat <= '0; m_prev <= '0; m_dl <= '0; m_rst <= 1'b0;
        end else begin
            m_prev <= phy_ctrl[19:16];
            m_dl   <= {m_dl[6:0], |phy_ctrl[19:16]};
            if (phy_ctrl[16] && !m_prev[0]) m_addr <= phy_ctrl[15:0];
            if (phy_ctrl[17] && !m_prev[1]) m_dat  <= phy_ctrl[15:0];
            if (phy_ctrl[18] && !m_prev[2]) begin
                if (m_dat[0]) m_rst <= 1'b1;
                else          m_mem[m_addr[3:0]] <= m_dat;
            end
            if (!phy_ctrl[18] && m_prev[2]) m_rst <= 1'b0;
        end
    end

    assign phy_ack   = stuck ? 1'b1 : (mute || m_rst) ? 1'b0 : m_dl[lat];
    assign phy_rdata = m_mem[m_addr[3:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [15:0] dat,
                           output int cyc, output logic e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = dat;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        if (op != 2'd3) chk(!cmd_ready, "R9 busy after accept", 32'(cmd_ready), 0);
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        e = err;
        chk(phy_ctrl[15:0] == dat, "R12 operand held", 32'(phy_ctrl[15:0]), 32'(dat));
        @(negedge clk);
        chk(!done && !err, "R9 done one cycle", 32'({done, err}), 0);
    endtask

    task automatic t_reset();
        chk(cmd_ready && !done && !err && phy_ctrl == '0, "R1 reset state",
            32'({cmd_ready, done, err, phy_ctrl}), 32'h400000);
    endtask

    task automatic t_addr();
        int c; logic e;
        run_cmd(2'd0, 16'h0005, c, e);
        chk(!e, "R2 addr no error", 32'(e), 0);
        chk(m_addr == 16'h0005, "R2 addr captured", 32'(m_addr), 32'h5);
        chk(c == 10, "R6 addr cycle count", 32'(c), 10);
    endtask

    task automatic t_write_read();
        int c; logic e;
        run_cmd(2'd0, 16'h0003, c, e);
        run_cmd(2'd1, 16'hBEE0, c, e);
        chk(!e && m_mem[3] == 16'hBEE0, "R3 write stored", 32'(m_mem[3]), 32'hBEE0);
        chk(c == 20, "R3 write two exchanges", 32'(c), 20);
        run_cmd(2'd0, 16'h0006, c, e);
        run_cmd(2'd2, 16'h0000, c, e);
        chk(!e && rd_data == 16'hA006, "R5 read data", 32'(rd_data), 32'hA006);
        run_cmd(2'd0, 16'h0003, c, e);
        run_cmd(2'd2, 16'h0000, c, e);
        chk(rd_data == 16'hBEE0, "R5 read back", 32'(rd_data), 32'hBEE0);
    endtask

    task automatic t_reset_write();
        int c; logic e;
        run_cmd(2'd0, 16'h0003, c, e);
        run_cmd(2'd1, 16'h8001, c, e);
        chk(!e && c == 10, "R4 reset write quick done", 32'(c), 10);
        chk(phy_ctrl[19:16] == 4'b0100, "R4 write strobe lingers",
            32'(phy_ctrl[19:16]), 32'h4);
        chk(m_mem[3] == 16'hBEE0, "R4 no data stored", 32'(m_mem[3]), 32'hBEE0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h0009;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(phy_ctrl[19:16] == 4'b0001, "R4 accept clears write strobe",
            32'(phy_ctrl[19:16]), 32'h1);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_late_ack();
        int c; logic e;
        lat = 7;
        run_cmd(2'd0, 16'h0002, c, e);
        chk(!e && c == 18, "R6 late ack inside budget", 32'(c), 18);
        lat = 0;
    endtask

    task automatic t_timeout_up();
        int c; logic e;
        run_cmd(2'd0, 16'h0007, c, e);
        mute = 1'b1;
        run_cmd(2'd1, 16'h1234, c, e);
        mute = 1'b0;
        chk(e, "R7 ack-high timeout err", 32'(e), 1);
        chk(c == 9 * (G + 1) + 1, "R7 timeout timing", 32'(c), 32'(9 * (G + 1) + 1));
        chk(phy_ctrl[19:16] == 4'b0000, "R7 strobes low", 32'(phy_ctrl[19:16]), 0);
        chk(m_mem[7] == 16'hA007, "R7 write aborted", 32'(m_mem[7]), 32'hA007);
    endtask

    task automatic t_timeout_dn();
        int c; logic e;
        stuck = 1'b1;
        run_cmd(2'd0, 16'h0004, c, e);
        stuck = 1'b0;
        chk(e && c == 9 * (G + 1) + 2, "R8 ack-low timeout", 32'(c),
            32'(9 * (G + 1) + 2));
        chk(phy_ctrl[19:16] == 4'b0000, "R8 strobes low", 32'(phy_ctrl[19:16]), 0);
    endtask

    task automatic t_bad_op();
        int c; logic e;
        run_cmd(2'd3, 16'h0011, c, e);
        chk(e && c == 0, "R10 invalid op", 32'({e, 8'(c)}), 32'h100);
        chk(phy_ctrl[19:16] == 4'b0000, "R10 no strobe", 32'(phy_ctrl[19:16]), 0);
    endtask

    task automatic t_idle_ignore();
        cmd_valid = 1'b0; cmd_op = 2'd1; cmd_data = 16'hFFFF;
        repeat (5) @(negedge clk);
        chk(cmd_ready && phy_ctrl[19:16] == 0, "R9 no valid no accept",
            32'(phy_ctrl[19:16]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_write_read();
        t_reset_write();
        t_late_ack();
        t_timeout_up();
        t_timeout_dn();
        t_bad_op();
        t_idle_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule